// File: doc/BRIEF.md
# Time-Slice Singles Word Transmitter

This block moves singles event words from the detector side of a system to an aggregating board. It uses a fixed time-slice schedule. It generates the slice boundary pulse from the system clock. At each boundary it hands up to four queued words to four parallel output sets. Each set has four serial lanes and sends its whole word within that one slice, so the receiver can treat every slice as a self-contained frame of at most four words.

Two slice lengths are supported. A short slice lasts 8 clocks and carries 32-bit words. A long slice lasts 16 clocks and carries 64-bit words. The most significant bit of the active word width is always sent as a one, which marks the slot as occupied. A set with nothing to send keeps its lanes at zero for the whole slice. Words arrive one per clock into a 16-entry queue. A word that arrives while the queue is full is dropped and counted in a saturating counter.

Top module: `slice_word_tx`

## Requirements
- R1: While reset is held, all lanes are zero, the drop counter is zero, the active mode is short (`long_mode_o` = 0) and `slice_bnd_o` is 1.
- R2: `slice_bnd_o` is high for exactly one clock per slice. Boundaries are 8 clocks apart in short mode and 16 clocks apart in long mode.
- R3: `long_req_i` is sampled only in the last clock of a slice. A request raised mid-slice leaves `long_mode_o` unchanged until the next boundary clock, where it takes effect.
- R4: Lane k of set s is `lane_o[4*s+k]`. On clock j of a slice (j = 0 is the boundary clock), that lane carries bit 4*j+k of the framed word. All 32 or 64 bits therefore leave within the slice.
- R5: Framing depends on the mode of the slice in which a word is sent. In short mode the framed word is `in_word_i[30:0]` with bit 31 forced to 1, and input bits 63:31 are ignored. In long mode it is `in_word_i[62:0]` with bit 63 forced to 1, and input bit 63 is ignored.
- R6: Words held in the queue during the last clock of a slice go out in the next slice. The oldest goes to set 0, the next to set 1, and so on, up to four words. The rest keep their order for later slices.
- R7: A word captured on the last clock of a slice is not sent in the slice that follows; it waits one more slice.
- R8: A set with no word assigned drives all four lanes to zero for the whole slice.
- R9: The queue holds 16 words. A word offered while 16 are held is dropped, and `ovf_cnt_o` increments by one.
- R10: `ovf_cnt_o` never decreases except by reset, and it stays at 255 once it reaches 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| long_req_i | input | 1 | Requested mode, 1 = long (16-clock, 64-bit) |
| in_valid_i | input | 1 | Offer of a singles word this clock |
| in_word_i | input | 64 | Singles word payload |
| lane_o | output | 16 | Four sets of four serial lanes |
| slice_bnd_o | output | 1 | High on the first clock of each slice |
| long_mode_o | output | 1 | Mode of the current slice |
| ovf_cnt_o | output | 8 | Saturating count of dropped words |

## Verification
Some properties are checked on every cycle. These are the spacing and single-clock width of the boundary pulse for the mode of the slice that ends, the mode staying constant between boundaries, and the drop counter being monotonic and saturating. Other behaviour can only be shown by the directed scenarios. This covers lane bit placement and valid-bit framing, the oldest-first assignment to sets, the one-slice wait of a word that arrives on the last clock, zero lanes for idle sets, and the exact number of dropped words when the queue fills.

// File: rtl/swt_pkg.sv
package swt_pkg;

   typedef enum logic {
      MODE_SHORT = 1'b0,
      MODE_LONG  = 1'b1
   } slice_mode_e;

   // number of clocks a slice needs to carry a word of the given width
   function automatic int slice_clocks(input int word_bits, input int lanes);
      return word_bits / lanes;
   endfunction

endpackage

// File: rtl/swt_slice_timer.sv
module swt_slice_timer
   import swt_pkg::*;
#(
   parameter int SHORT_LEN = 8,
   parameter int LONG_LEN  = 16,
   localparam int CW       = $clog2(LONG_LEN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic long_req,
   output logic bnd,
   output logic wrap,
   output logic next_long,
   output logic long_mode
);

   logic [CW-1:0] cnt_q;
   slice_mode_e   mode_q;
   logic [CW-1:0] last_idx;

   assign last_idx  = (mode_q == MODE_LONG) ? CW'(LONG_LEN - 1) : CW'(SHORT_LEN - 1);
   assign wrap      = (cnt_q == last_idx);
   assign bnd       = (cnt_q == '0);
   assign next_long = wrap ? long_req : (mode_q == MODE_LONG);
   assign long_mode = (mode_q == MODE_LONG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         mode_q <= MODE_SHORT;
      end else if (wrap) begin
         cnt_q  <= '0;
         mode_q <= long_req ? MODE_LONG : MODE_SHORT;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/swt_fifo.sv
module swt_fifo #(
   parameter int W      = 64,
   parameter int DEPTH  = 16,
   parameter int NPOP   = 4,
   parameter int OVF_W  = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int LW    = AW + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [W-1:0]             din,
   input  logic                     pop,
   output logic [NPOP-1:0][W-1:0]   head_word,
   output logic [NPOP-1:0]          head_vld,
   output logic [OVF_W-1:0]         ovf_cnt
);

   logic [W-1:0]     mem_q [DEPTH];
   logic [AW-1:0]    wr_q, rd_q;
   logic [LW-1:0]    level_q;
   logic [LW-1:0]    pop_n;
   logic             accept;
   logic [OVF_W-1:0] ovf_q;

   assign accept = push && (level_q < LW'(DEPTH));

   always_comb begin
      if (!pop)                     pop_n = '0;
      else if (level_q >= LW'(NPOP)) pop_n = LW'(NPOP);
      else                          pop_n = level_q;
   end

   for (genvar s = 0; s < NPOP; s++) begin : g_head
      assign head_word[s] = mem_q[rd_q + AW'(s)];
      assign head_vld[s]  = (level_q > LW'(s));
   end

   always_ff @(posedge clk) begin
      if (accept) mem_q[wr_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= '0;
         rd_q    <= '0;
         level_q <= '0;
         ovf_q   <= '0;
      end else begin
         if (accept) wr_q <= wr_q + 1'b1;
         rd_q    <= rd_q + pop_n[AW-1:0];
         level_q <= level_q + LW'(accept) - pop_n;
         if (push && !accept && (ovf_q != '1)) ovf_q <= ovf_q + 1'b1;
      end
   end

   assign ovf_cnt = ovf_q;

endmodule

// File: rtl/swt_lane_set.sv
module swt_lane_set #(
   parameter int W       = 64,
   parameter int SHORT_W = 32,
   parameter int LANES   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             vld,
   input  logic             long_sel,
   input  logic [W-1:0]     word,
   output logic [LANES-1:0] lanes
);

   logic [W-1:0] sr_q;
   logic [W-1:0] framed;
   logic [W-1:0] long_f;
   logic [SHORT_W-1:0] short_f;

   assign long_f  = word | {1'b1, {(W-1){1'b0}}};
   assign short_f = word[SHORT_W-1:0] | {1'b1, {(SHORT_W-1){1'b0}}};
   assign framed  = long_sel ? long_f : {{(W-SHORT_W){1'b0}}, short_f};

   always_ff @(posedge clk) begin
      if (!rst_n)    sr_q <= '0;
      else if (load) sr_q <= vld ? framed : '0;
      else           sr_q <= sr_q >> LANES;
   end

   assign lanes = sr_q[LANES-1:0];

endmodule

// File: rtl/slice_word_tx.sv
module slice_word_tx
   import swt_pkg::*;
#(
   parameter int N_SETS   = 4,
   parameter int LANES    = 4,
   parameter int WORD_W   = 64,
   parameter int SHORT_W  = 32,
   parameter int DEPTH    = 16,
   parameter int OVF_W    = 8,
   localparam int SHORT_LEN = slice_clocks(SHORT_W, LANES),
   localparam int LONG_LEN  = slice_clocks(WORD_W, LANES),
   localparam int LANE_W    = N_SETS * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              long_req_i,
   input  logic              in_valid_i,
   input  logic [WORD_W-1:0] in_word_i,
   output logic [LANE_W-1:0] lane_o,
   output logic              slice_bnd_o,
   output logic              long_mode_o,
   output logic [OVF_W-1:0]  ovf_cnt_o
);

   if (WORD_W != 2 * SHORT_W) begin : g_bad_width
      $error("long word must be twice the short word");
   end
   if ((SHORT_W % LANES) != 0) begin : g_bad_lanes
      $error("short word must split evenly over the lanes");
   end
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < N_SETS) begin : g_bad_depth
      $error("queue depth must be a power of two and hold one slice of words");
   end

   logic                          wrap, next_long;
   logic [N_SETS-1:0][WORD_W-1:0] head_word;
   logic [N_SETS-1:0]             head_vld;

   swt_slice_timer #(
      .SHORT_LEN (SHORT_LEN),
      .LONG_LEN  (LONG_LEN)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .long_req  (long_req_i),
      .bnd       (slice_bnd_o),
      .wrap      (wrap),
      .next_long (next_long),
      .long_mode (long_mode_o)
   );

   swt_fifo #(
      .W     (WORD_W),
      .DEPTH (DEPTH),
      .NPOP  (N_SETS),
      .OVF_W (OVF_W)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (in_valid_i),
      .din       (in_word_i),
      .pop       (wrap),
      .head_word (head_word),
      .head_vld  (head_vld),
      .ovf_cnt   (ovf_cnt_o)
   );

   for (genvar s = 0; s < N_SETS; s++) begin : g_set
      swt_lane_set #(
         .W       (WORD_W),
         .SHORT_W (SHORT_W),
         .LANES   (LANES)
      ) u_set (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (wrap),
         .vld      (head_vld[s]),
         .long_sel (next_long),
         .word     (head_word[s]),
         .lanes    (lane_o[s*LANES +: LANES])
      );
   end

endmodule

// File: rtl/swt_chk.sv
module swt_chk #(
   parameter int OVF_W     = 8,
   parameter int SHORT_LEN = 8,
   parameter int LONG_LEN  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             slice_bnd_o,
   input logic             long_mode_o,
   input logic [OVF_W-1:0] ovf_cnt_o
);

   logic [7:0] gap_q;
   logic       seen_q;
   logic       mode_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q       <= '0;
         seen_q      <= 1'b0;
         mode_prev_q <= 1'b0;
      end else begin
         // R2
         if (slice_bnd_o && seen_q) begin
            bnd_gap_chk: assert (gap_q == (mode_prev_q ? 8'(LONG_LEN) : 8'(SHORT_LEN)))
               else $error("boundary spacing %0d", gap_q);
         end
         gap_q       <= slice_bnd_o ? 8'd1 : gap_q + 8'd1;
         seen_q      <= seen_q | slice_bnd_o;
         mode_prev_q <= long_mode_o;
      end
   end

   // R2
   bnd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slice_bnd_o |=> !slice_bnd_o);

   // R3
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slice_bnd_o |-> $stable(long_mode_o));

   // R10
   ovf_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_cnt_o >= $past(ovf_cnt_o));

   // R9
   ovf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_cnt_o - $past(ovf_cnt_o)) <= OVF_W'(1));

   // R10
   ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_cnt_o == '1) |=> (ovf_cnt_o == '1));

endmodule

bind slice_word_tx swt_chk #(
   .OVF_W     (OVF_W),
   .SHORT_LEN (SHORT_LEN),
   .LONG_LEN  (LONG_LEN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .slice_bnd_o (slice_bnd_o),
   .long_mode_o (long_mode_o),
   .ovf_cnt_o   (ovf_cnt_o)
);

// File: tb/slice_word_tx_tb.sv
module slice_word_tx_tb;

   localparam int CLK_PERIOD = 12;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        long_req;
   logic        in_valid;
   logic [63:0] in_word;
   logic [15:0] lane;
   logic        bnd;
   logic        lmode;
   logic [7:0]  ovf;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   slice_word_tx u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .long_req_i  (long_req),
      .in_valid_i  (in_valid),
      .in_word_i   (in_word),
      .lane_o      (lane),
      .slice_bnd_o (bnd),
      .long_mode_o (lmode),
      .ovf_cnt_o   (ovf)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] frame(input logic [63:0] w, input bit lng);
      if (lng) return w | 64'h8000_0000_0000_0000;
      return {32'h0, w[31:0] | 32'h8000_0000};
   endfunction

   task automatic wait_bnd();
      do @(negedge clk); while (bnd !== 1'b1);
   endtask

   // called at the negedge of a boundary clock; ends at the slice's last clock
   task automatic capture(input int len, output logic [63:0] got [4]);
      for (int s = 0; s < 4; s++) got[s] = '0;
      for (int j = 0; j < len; j++) begin
         if (j > 0) @(negedge clk);
         for (int s = 0; s < 4; s++)
            for (int k = 0; k < 4; k++)
               got[s][4*j+k] = lane[4*s+k];
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; long_req = 1'b0; in_valid = 1'b0; in_word = '0;
      repeat (3) @(negedge clk);
      chk("R1 lanes", 64'(lane), 64'h0);
      chk("R1 ovf", 64'(ovf), 64'h0);
      chk("R1 mode", 64'(lmode), 64'h0);
      chk("R1 bnd", 64'(bnd), 64'h1);
      rst_n = 1'b1;
   endtask

   task automatic t_period_short();
      int n;
      wait_bnd();
      for (int r = 0; r < 2; r++) begin
         n = 0;
         do begin @(negedge clk); n++; end while (bnd !== 1'b1);
         chk("R2 short period", 64'(n), 64'd8);
      end
   endtask

   task automatic t_single();
      logic [63:0] got [4];
      logic [63:0] w = 64'hDEAD_BEEF_1234_5678; // bit 31 clear, upper bits set
      wait_bnd();
      in_valid = 1'b1; in_word = w;
      @(negedge clk);
      in_valid = 1'b0;
      wait_bnd();
      capture(8, got);
      chk("R5 R4 short frame set0", got[0], frame(w, 1'b0));
      for (int s = 1; s < 4; s++) chk("R8 idle set", got[s], 64'h0);
   endtask

   task automatic t_burst();
      logic [63:0] got [4];
      wait_bnd();
      for (int i = 0; i < 6; i++) begin
         in_valid = 1'b1; in_word = 64'hFFFF_FFFF_0A0B_0C00 + 64'(i);
         @(negedge clk);
      end
      in_valid = 1'b0;
      wait_bnd();
      capture(8, got);
      for (int s = 0; s < 4; s++)
         chk("R6 order first slice", got[s], frame(64'hFFFF_FFFF_0A0B_0C00 + 64'(s), 1'b0));
      @(negedge clk);
      capture(8, got);
      chk("R6 leftover set0", got[0], frame(64'hFFFF_FFFF_0A0B_0C04, 1'b0));
      chk("R6 leftover set1", got[1], frame(64'hFFFF_FFFF_0A0B_0C05, 1'b0));
      chk("R8 idle set2", got[2], 64'h0);
      chk("R8 idle set3", got[3], 64'h0);
   endtask

   task automatic t_late();
      logic [63:0] got [4];
      logic [63:0] w = 64'h0000_0000_5566_7788;
      wait_bnd();
      repeat (7) @(negedge clk);
      in_valid = 1'b1; in_word = w;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R7 at boundary", 64'(bnd), 64'h1);
      capture(8, got);
      for (int s = 0; s < 4; s++) chk("R7 not yet sent", got[s], 64'h0);
      @(negedge clk);
      capture(8, got);
      chk("R7 sent one slice later", got[0], frame(w, 1'b0));
   endtask

   task automatic t_mode_long();
      logic [63:0] got [4];
      logic [63:0] w = 64'h0123_4567_89AB_CDEF;
      int n;
      wait_bnd();
      repeat (2) @(negedge clk);
      long_req = 1'b1;
      repeat (5) @(negedge clk);
      chk("R3 mode held mid-slice", 64'(lmode), 64'h0);
      @(negedge clk);
      chk("R3 boundary reached", 64'(bnd), 64'h1);
      chk("R3 mode applied at boundary", 64'(lmode), 64'h1);
      n = 0;
      do begin @(negedge clk); n++; end while (bnd !== 1'b1);
      chk("R2 long period", 64'(n), 64'd16);
      in_valid = 1'b1; in_word = w;
      @(negedge clk);
      in_valid = 1'b0;
      wait_bnd();
      capture(16, got);
      chk("R5 R4 long frame set0", got[0], frame(w, 1'b1));
      chk("R8 idle set1 long", got[1], 64'h0);
   endtask

   task automatic t_overflow();
      logic [63:0] got [4];
      logic [63:0] base = 64'h7A00_0000_0000_0000;
      wait_bnd();
      for (int c = 0; c < 32; c++) begin
         if (c == 26) chk("R9 drop count", 64'(ovf), 64'd5);
         if (c <= 14) begin
            in_valid = 1'b1; in_word = base + 64'(c);
         end else if (c >= 16 && c <= 25) begin
            in_valid = 1'b1; in_word = base + 64'(c - 1);
         end else begin
            in_valid = 1'b0;
         end
         if (c >= 16)
            for (int s = 0; s < 4; s++)
               for (int k = 0; k < 4; k++)
                  got[s][4*(c-16)+k] = lane[4*s+k];
         @(negedge clk);
      end
      in_valid = 1'b0;
      for (int s = 0; s < 4; s++)
         chk("R6 oldest first after fill", got[s], frame(base + 64'(s), 1'b1));
      capture(16, got);
      for (int s = 0; s < 4; s++)
         chk("R9 kept words in order", got[s], frame(base + 64'(s + 4), 1'b1));
   endtask

   task automatic t_saturate();
      logic [63:0] got [4];
      for (int i = 0; i < 400; i++) begin
         in_valid = 1'b1; in_word = 64'(i);
         @(negedge clk);
      end
      in_valid = 1'b0;
      @(negedge clk);
      chk("R10 saturated", 64'(ovf), 64'd255);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R10 stays saturated", 64'(ovf), 64'd255);
      repeat (6) wait_bnd();
      capture(16, got);
      for (int s = 0; s < 4; s++) chk("R8 drained sets zero", got[s], 64'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_period_short();
      t_single();
      t_burst();
      t_late();
      t_mode_long();
      t_overflow();
      t_saturate();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule